// File: doc/BRIEF.md
# PS/2 Keyboard Matrix Emulator

This block turns the byte stream of a PS/2 keyboard into the state of a scanned switch matrix. Each received make or break code sets or clears one bit in a 10-column by 8-row key array. A host then reads that array the way it would read a real matrix: it drives a column and a row select and reads back a single key bit. It also watches an interrupt line that reports activity in the column it is currently looking at.

Row 0 of the matrix does not hold keys. It returns the eight configuration switch inputs, one per column position. A free-running scan mode lets an internal column counter step through the columns on every 1 MHz enable pulse, in place of the host's column input. One key drives a dedicated break line and never appears in the matrix.

Top module: `kbd_matrix_emu`

## Requirements
- R1: A PS/2 frame has a start bit of 0, eight data bits sent least significant bit first, an odd parity bit and a stop bit of 1. Each bit is sampled on a falling edge of the synchronized PS/2 clock. A valid frame carrying a mapped code sets that key's matrix bit, for example code 0x1C at column 1, row 4.
- R2: A frame with wrong parity, or with a stop bit of 0, is dropped and changes no key state.
- R3: The byte 0xF0 makes the next code a release, which clears its bit. The release flag is cleared once that code has been handled, so a later code is a press again.
- R4: The byte 0xE0 makes the next code an extended code and is cleared after that code. Extended 0x75 maps to column 9, row 3. Plain 0x75 and plain 0x72 are unmapped and ignored.
- R5: When scan mode is off, `keypress_o` is 1 exactly when the bit at (`column_i`, `row_i`) is set. Columns 10 to 15 read as 0.
- R6: `int_o` is 1 when any key in rows 1 to 7 of the active column is down. Row 0 never drives it, and columns 10 to 15 never drive it.
- R7: Row 0 at column c (0 to 7) reads `dip_i[c]`. Row 0 at columns 8 and 9 reads 0.
- R8: When `autoscan_i` is 1, an internal column counter replaces `column_i` and advances by one on each cycle with `clken_1mhz_i` high. It wraps from 9 to 0.
- R9: Code 0x07 drives `break_o`: 1 after a press and 0 after its 0xF0 release. The code touches no matrix bit.
- R10: An asynchronous low on `rst_ni` clears every key, `break_o`, both prefix flags and the column counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clken_1mhz_i | input | 1 | 1 MHz enable pulse that steps the scan counter |
| ps2_clk_i | input | 1 | PS/2 clock line (asynchronous) |
| ps2_data_i | input | 1 | PS/2 data line (asynchronous) |
| autoscan_i | input | 1 | 1 selects the internal column counter |
| column_i | input | 4 | Host column select |
| row_i | input | 3 | Host row select |
| dip_i | input | 8 | Configuration switches shown in row 0 |
| keypress_o | output | 1 | State of the selected matrix position |
| int_o | output | 1 | Any key down in rows 1 to 7 of the active column |
| break_o | output | 1 | Break key held |

## Verification
A wrong key bit or prefix flag does not show when the fault occurs. It shows only when the host selects the affected position, or when the next code arrives and lands on the wrong bit. The bench therefore reads back specific positions after each frame, including the code that follows every prefix. A counter fault shows on `int_o` at the first enable pulse that should reach a column holding a key. The bench counts pulses to catch both the reach and the wrap within one pulse.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned KEY_COLS = 10;
  localparam int unsigned KEY_ROWS = 8;
  localparam int unsigned COL_W    = 4;
  localparam int unsigned ROW_W    = 3;
  localparam int unsigned DIP_W    = 8;

  localparam logic [7:0] CODE_REL = 8'hF0;
  localparam logic [7:0] CODE_EXT = 8'hE0;

  typedef struct packed {
    logic             hit;
    logic             brk;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
  } key_loc_t;

  // {extended, code} -> matrix position; row 0 is reserved for switches
  function automatic key_loc_t map_code(input logic ext, input logic [7:0] code);
    key_loc_t m;
    m = '0;
    case ({ext, code})
      9'h016: m = '{1'b1, 1'b0, 4'd0, 3'd3};
      9'h01E: m = '{1'b1, 1'b0, 4'd1, 3'd3};
      9'h026: m = '{1'b1, 1'b0, 4'd1, 3'd1};
      9'h025: m = '{1'b1, 1'b0, 4'd2, 3'd1};
      9'h015: m = '{1'b1, 1'b0, 4'd0, 3'd1};
      9'h01D: m = '{1'b1, 1'b0, 4'd1, 3'd2};
      9'h01C: m = '{1'b1, 1'b0, 4'd1, 3'd4};
      9'h01B: m = '{1'b1, 1'b0, 4'd1, 3'd5};
      9'h01A: m = '{1'b1, 1'b0, 4'd1, 3'd6};
      9'h029: m = '{1'b1, 1'b0, 4'd2, 3'd6};
      9'h076: m = '{1'b1, 1'b0, 4'd0, 3'd6};
      9'h012: m = '{1'b1, 1'b0, 4'd0, 3'd7};
      9'h014: m = '{1'b1, 1'b0, 4'd1, 3'd7};
      9'h05A: m = '{1'b1, 1'b0, 4'd9, 3'd4};
      9'h175: m = '{1'b1, 1'b0, 4'd9, 3'd3};
      9'h172: m = '{1'b1, 1'b0, 4'd9, 3'd2};
      9'h007: m = '{1'b0, 1'b1, 4'd0, 3'd0};
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/kbd_ps2_rx.sv
module kbd_ps2_rx #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic       clk_prev;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       par_q;
  logic       clk_s, dat_s, fall;

  assign clk_s = clk_sync[SYNC_STAGES-1];
  assign dat_s = dat_sync[SYNC_STAGES-1];
  assign fall  = clk_prev & ~clk_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync <= '1;
      dat_sync <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ps2_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ps2_data_i};
      clk_prev <= clk_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (fall) begin
        if (bit_cnt == 4'd0) begin
          if (!dat_s) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shreg   <= {dat_s, shreg[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par_q   <= dat_s;
          bit_cnt <= bit_cnt + 4'd1;
        end else begin
          bit_cnt <= '0;
          if (dat_s && (^{shreg, par_q})) begin
            byte_o     <= shreg;
            byte_vld_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/kbd_decode.sv
module kbd_decode
  import kbd_pkg::*;
#(
  parameter int unsigned NCOL = KEY_COLS,
  parameter int unsigned NROW = KEY_ROWS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 byte_i,
  input  logic                       byte_vld_i,
  output logic [NCOL-1:0][NROW-1:0]  keys_o,
  output logic                       break_o
);
  logic     rel_q, ext_q;
  key_loc_t loc;

  always_comb loc = map_code(ext_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keys_o  <= '0;
      break_o <= 1'b0;
      rel_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else if (byte_vld_i) begin
      if (byte_i == CODE_REL) begin
        rel_q <= 1'b1;
      end else if (byte_i == CODE_EXT) begin
        ext_q <= 1'b1;
      end else begin
        if (loc.brk) break_o <= ~rel_q;
        else if (loc.hit && int'(loc.col) < NCOL && loc.row != '0)
          keys_o[loc.col][loc.row] <= ~rel_q;
        rel_q <= 1'b0;
        ext_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan
  import kbd_pkg::*;
#(
  parameter int unsigned NCOL = KEY_COLS,
  parameter int unsigned NROW = KEY_ROWS,
  parameter int unsigned CW   = COL_W,
  parameter int unsigned RW   = ROW_W,
  parameter int unsigned NDIP = DIP_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clken_i,
  input  logic                      autoscan_i,
  input  logic [CW-1:0]             column_i,
  input  logic [RW-1:0]             row_i,
  input  logic [NDIP-1:0]           dip_i,
  input  logic [NCOL-1:0][NROW-1:0] keys_i,
  output logic [CW-1:0]             scan_col_o,
  output logic                      keypress_o,
  output logic                      int_o
);
  localparam logic [CW-1:0] LAST_COL = CW'(NCOL - 1);

  logic [CW-1:0]             act_col;
  logic                      col_ok;
  logic [NCOL-1:0][NROW-1:0] view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_col_o <= '0;
    else if (autoscan_i && clken_i)
      scan_col_o <= (scan_col_o == LAST_COL) ? '0 : scan_col_o + CW'(1);
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    if (c < NDIP) begin : g_dip
      assign view[c] = {keys_i[c][NROW-1:1], dip_i[c]};
    end else begin : g_nodip
      assign view[c] = {keys_i[c][NROW-1:1], 1'b0};
    end
  end

  assign act_col = autoscan_i ? scan_col_o : column_i;
  assign col_ok  = int'(act_col) < NCOL;

  always_comb begin
    keypress_o = 1'b0;
    int_o      = 1'b0;
    if (col_ok) begin
      keypress_o = view[act_col][row_i];
      int_o      = |view[act_col][NROW-1:1];
    end
  end
endmodule

// File: rtl/kbd_matrix_emu.sv
module kbd_matrix_emu
  import kbd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clken_1mhz_i,
  input  logic             ps2_clk_i,
  input  logic             ps2_data_i,
  input  logic             autoscan_i,
  input  logic [COL_W-1:0] column_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [DIP_W-1:0] dip_i,
  output logic             keypress_o,
  output logic             int_o,
  output logic             break_o
);
  logic [7:0]                        rx_byte;
  logic                              byte_vld;
  logic [KEY_COLS-1:0][KEY_ROWS-1:0] key_q;
  logic [COL_W-1:0]                  scan_col;

  kbd_ps2_rx #(.SYNC_STAGES(2)) i_rx (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_data_i,
    .byte_o(rx_byte), .byte_vld_o(byte_vld)
  );

  kbd_decode #(.NCOL(KEY_COLS), .NROW(KEY_ROWS)) i_dec (
    .clk_i, .rst_ni, .byte_i(rx_byte), .byte_vld_i(byte_vld),
    .keys_o(key_q), .break_o
  );

  kbd_scan #(.NCOL(KEY_COLS), .NROW(KEY_ROWS), .CW(COL_W), .RW(ROW_W), .NDIP(DIP_W)) i_scan (
    .clk_i, .rst_ni, .clken_i(clken_1mhz_i), .autoscan_i, .column_i, .row_i,
    .dip_i, .keys_i(key_q), .scan_col_o(scan_col), .keypress_o, .int_o
  );
endmodule

// File: rtl/kbd_matrix_emu_chk.sv
module kbd_matrix_emu_chk
  import kbd_pkg::*;
(
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              clken_1mhz_i,
  input logic                              autoscan_i,
  input logic [COL_W-1:0]                  column_i,
  input logic [ROW_W-1:0]                  row_i,
  input logic [DIP_W-1:0]                  dip_i,
  input logic                              keypress_o,
  input logic                              int_o,
  input logic                              break_o,
  input logic                              byte_vld,
  input logic [COL_W-1:0]                  scan_col,
  input logic [KEY_COLS-1:0][KEY_ROWS-1:0] key_q
);
  assert_col_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(scan_col) < KEY_COLS);

  assert_col_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autoscan_i && clken_1mhz_i && int'(scan_col) == KEY_COLS - 1 |=> scan_col == '0);

  assert_keys_need_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(key_q));

  assert_break_need_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(break_o));

  assert_no_col_beyond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !autoscan_i && int'(column_i) >= KEY_COLS |-> !int_o && !keypress_o);

  assert_dip_row0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !autoscan_i && row_i == '0 && int'(column_i) < DIP_W |-> keypress_o == dip_i[column_i[2:0]]);
endmodule

bind kbd_matrix_emu kbd_matrix_emu_chk i_chk (
  .clk_i, .rst_ni, .clken_1mhz_i, .autoscan_i, .column_i, .row_i, .dip_i,
  .keypress_o, .int_o, .break_o, .byte_vld, .scan_col, .key_q
);

// File: tb/test_kbd_matrix_emu.sv
module test_kbd_matrix_emu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clken = 1'b0;
  logic       ps2_clk = 1'b1;
  logic       ps2_dat = 1'b1;
  logic       autoscan = 1'b0;
  logic [3:0] col = '0;
  logic [2:0] row = '0;
  logic [7:0] dip = '0;
  logic       keypress, intr, brk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int    sel;
    logic  exp;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  kbd_matrix_emu i_kbd_matrix_emu (
    .clk_i(clk), .rst_ni(rst_n), .clken_1mhz_i(clken),
    .ps2_clk_i(ps2_clk), .ps2_data_i(ps2_dat),
    .autoscan_i(autoscan), .column_i(col), .row_i(row), .dip_i(dip),
    .keypress_o(keypress), .int_o(intr), .break_o(brk)
  );

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic  act;
        it = sb.pop_front();
        act = (it.sel == 0) ? keypress : (it.sel == 1) ? intr : brk;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input int sel, input logic exp, input string tag);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic pick(input int c, input int r);
    @(posedge clk); #1;
    col = 4'(c); row = 3'(r);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      ps2_dat = fr[i];
      repeat (10) @(posedge clk);
      ps2_clk = 1'b0;
      repeat (10) @(posedge clk);
      ps2_clk = 1'b1;
    end
    ps2_dat = 1'b1;
    repeat (30) @(posedge clk);
    #1;
  endtask

  task automatic pulse_en(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 clken = 1'b1;
      @(posedge clk); #1 clken = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    pick(1, 4);
    expect_out(0, 1'b0, "R10 reset keypress");
    expect_out(1, 1'b0, "R10 reset int");
    expect_out(2, 1'b0, "R10 reset break");

    send_byte(8'h1C);
    pick(1, 4); expect_out(0, 1'b1, "R1 press 0x1C");
    pick(1, 5); expect_out(0, 1'b0, "R5 neighbour row clear");
    expect_out(1, 1'b1, "R6 int col1");

    send_byte(8'h1B, 1, 0);
    pick(1, 5); expect_out(0, 1'b0, "R2 bad parity dropped");
    send_byte(8'h1B, 0, 1);
    expect_out(0, 1'b0, "R2 bad stop dropped");
    send_byte(8'h1B);
    expect_out(0, 1'b1, "R1 press 0x1B");

    send_byte(8'hF0); send_byte(8'h1C);
    pick(1, 4); expect_out(0, 1'b0, "R3 release 0x1C");
    pick(1, 5); expect_out(0, 1'b1, "R3 other key kept");
    send_byte(8'h1C);
    pick(1, 4); expect_out(0, 1'b1, "R3 release flag cleared");

    send_byte(8'hE0); send_byte(8'h75);
    pick(9, 3); expect_out(0, 1'b1, "R4 extended 0x75");
    send_byte(8'h72);
    pick(9, 2); expect_out(0, 1'b0, "R4 ext flag cleared");
    send_byte(8'hE0); send_byte(8'hF0); send_byte(8'h75);
    pick(9, 3); expect_out(0, 1'b0, "R4 extended release");

    dip = 8'b1010_0101;
    pick(0, 0); expect_out(0, 1'b1, "R7 dip col0");
    expect_out(1, 1'b0, "R6 row0 excluded");
    pick(1, 0); expect_out(0, 1'b0, "R7 dip col1");
    pick(7, 0); expect_out(0, 1'b1, "R7 dip col7");
    pick(8, 0); expect_out(0, 1'b0, "R7 col8 row0");
    pick(15, 1); expect_out(0, 1'b0, "R5 col15 empty");
    expect_out(1, 1'b0, "R6 col15 no int");

    send_byte(8'hF0); send_byte(8'h1C);
    send_byte(8'hF0); send_byte(8'h1B);
    send_byte(8'h5A);
    pick(0, 4);
    @(posedge clk); #1 autoscan = 1'b1;
    expect_out(1, 1'b0, "R8 scan starts col0");
    pulse_en(9);
    expect_out(1, 1'b1, "R8 scan reaches col9");
    expect_out(0, 1'b1, "R8 keypress follows scan");
    pulse_en(1);
    expect_out(1, 1'b0, "R8 wrap to col0");
    pulse_en(9);
    expect_out(1, 1'b1, "R8 second pass col9");
    @(posedge clk); #1 autoscan = 1'b0;
    expect_out(1, 1'b0, "R5 external col0 again");

    send_byte(8'h07);
    expect_out(2, 1'b1, "R9 break press");
    pick(0, 1); expect_out(1, 1'b0, "R9 no matrix bit");
    send_byte(8'hF0); send_byte(8'h07);
    expect_out(2, 1'b0, "R9 break release");
    send_byte(8'h07);
    expect_out(2, 1'b1, "R9 break again");

    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out(2, 1'b0, "R10 break cleared");
    pick(9, 4); expect_out(0, 1'b0, "R10 key cleared");
    @(posedge clk); #1 autoscan = 1'b1;
    expect_out(1, 1'b0, "R10 counter cleared");
    @(posedge clk); #1 autoscan = 1'b0;

    repeat (4) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule